// File: doc/BRIEF.md
# Time-Shared Offset-and-Scale Pipeline

This block turns the raw samples captured by one serial converter master into scaled results. For every channel it adds a per-channel signed offset to the unsigned raw sample and multiplies the sum by a per-channel signed fixed-point factor. A single multiplier does the work for all channels: after a sample set is accepted, the channels are issued into a three-stage pipeline one per cycle, lowest index first.

A fixed bit window of each full-precision product is written into that channel's slot of a packed result bus. One completion strobe is raised when the last channel's slot has been written. While a sample set is being worked through, the block reports busy and ignores new sample sets. Coefficients are loaded through a single-cycle write port. That port is locked while busy, so a run always uses one consistent set of coefficients.

Top module: `scl_scale_top`

## Requirements
- R1: While and right after synchronous active-low reset, `res_bus` is all zeros and `res_valid` and `busy` are low; all offsets and factors are reset to zero.
- R2: The value written for channel k is bits RES_MSB down to RES_LSB of the exact two's-complement product (raw_k + offset_k) × factor_k, with no rounding or saturation.
- R3: Channel k's result occupies `res_bus[k*RES_W +: RES_W]`, with RES_W = RES_MSB − RES_LSB + 1, so channel 0 is the lowest slice.
- R4: A `samp_valid` seen at a clock edge where `busy` is low is accepted. `busy` is high from the following cycle until the cycle in which `res_valid` pulses, when it is low again.
- R5: Counting the accepting edge as edge 0, channel k's slot changes at edge k+3. `res_valid` is high for exactly one cycle after edge N+2 (N = CHANNELS), and a new set can be accepted at the next edge.
- R6: A `samp_valid` at an edge where `busy` is high has no effect: the running set's results and timing are unchanged.
- R7: With `cfg_we` high at an edge where `busy` is low, `cfg_sel`=0 loads `cfg_data[OFFSET_W-1:0]` as the offset and `cfg_sel`=1 loads `cfg_data[FACTOR_W-1:0]` as the factor of channel `cfg_ch` (binary index). The write is used by every set accepted at a later edge.
- R8: A coefficient write at an edge where `busy` is high has no effect on any offset or factor.
- R9: The raw sample is treated as unsigned (all ones means 2^DATA_W − 1). The offset is sign-extended, and the sum is wide enough that extreme raw, offset and factor values give the exact product.
- R10: A slot keeps its value until the same channel is written again, across idle cycles and later coefficient writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_valid | input | 1 | Request to process the sample set on `samp_raw` |
| samp_raw | input | CHANNELS*DATA_W | Raw samples, channel 0 in the lowest slice |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 1 | 0 = offset, 1 = factor |
| cfg_ch | input | CIW | Channel index of the write |
| cfg_data | input | CFG_W | Coefficient value, right-aligned |
| res_bus | output | CHANNELS*RES_W | Packed scaled results |
| res_valid | output | 1 | One-cycle pulse when all slots of a set are written |
| busy | output | 1 | A sample set is being processed |

## Verification
The accepting edge is edge 0. Channel k's slot is due at edge k+3, and the completion pulse and the fall of busy are due at edge N+2. The bench's reference model advances a per-set cycle count at every edge and applies each expected slot update at exactly that count. All outputs are compared half a cycle after every edge, so any early, late or missing update is a miscompare in that same cycle. Sample sets or coefficient writes offered while busy are modelled as dropped. Back-to-back sets held on a constant request check that the next set is accepted on the edge after the completion pulse.

// File: rtl/scl_pkg.sv
package scl_pkg;

   typedef enum logic {
      COEF_OFFSET = 1'b0,
      COEF_FACTOR = 1'b1
   } coef_sel_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/scl_coef_bank.sv
module scl_coef_bank #(
   parameter int CHANNELS = 8,
   parameter int OFFSET_W = 16,
   parameter int FACTOR_W = 18,
   parameter int CIW      = 3,
   parameter int CFG_W    = 18
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lock,
   input  logic                       wr_en,
   input  scl_pkg::coef_sel_e         wr_sel,
   input  logic [CIW-1:0]             wr_ch,
   input  logic [CFG_W-1:0]           wr_data,
   input  logic [CIW-1:0]             rd_ch,
   output logic signed [OFFSET_W-1:0] rd_off,
   output logic signed [FACTOR_W-1:0] rd_fac
);
   import scl_pkg::*;

   logic signed [OFFSET_W-1:0] off_q [CHANNELS];
   logic signed [FACTOR_W-1:0] fac_q [CHANNELS];

   logic wr_ok;
   assign wr_ok = wr_en && !lock;

   for (genvar c = 0; c < CHANNELS; c++) begin : g_coef
      logic hit;
      assign hit = wr_ok && (wr_ch == CIW'(c));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            off_q[c] <= '0;
            fac_q[c] <= '0;
         end else if (hit) begin
            if (wr_sel == COEF_OFFSET) off_q[c] <= wr_data[OFFSET_W-1:0];
            else                       fac_q[c] <= wr_data[FACTOR_W-1:0];
         end
      end

      // R8
      cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (lock && wr_en) |=> ($stable(off_q[c]) && $stable(fac_q[c])));
   end

   assign rd_off = off_q[rd_ch];
   assign rd_fac = fac_q[rd_ch];

endmodule

// File: rtl/scl_issue_seq.sv
module scl_issue_seq #(
   parameter int CHANNELS = 8,
   parameter int CIW      = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           drain_done,
   output logic           accept,
   output logic           busy,
   output logic           iss_vld,
   output logic [CIW-1:0] iss_ch
);
   localparam logic [CIW-1:0] LAST_CH = CIW'(CHANNELS - 1);

   logic           busy_q;
   logic           act_q;
   logic [CIW-1:0] idx_q;

   assign accept  = start && !busy_q;
   assign busy    = busy_q;
   assign iss_vld = act_q;
   assign iss_ch  = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         act_q  <= 1'b0;
         idx_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         act_q  <= 1'b1;
         idx_q  <= '0;
      end else begin
         if (act_q) begin
            if (idx_q == LAST_CH) act_q <= 1'b0;
            else                  idx_q <= idx_q + 1'b1;
         end
         if (drain_done) busy_q <= 1'b0;
      end
   end

   // R4
   issue_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> busy_q);

   // R4
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !drain_done) |=> busy_q);

   // R6
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && act_q && idx_q != '0) |=> (idx_q != '0 || !act_q));

endmodule

// File: rtl/scl_mac_pipe.sv
module scl_mac_pipe #(
   parameter int DATA_W   = 16,
   parameter int OFFSET_W = 16,
   parameter int FACTOR_W = 18,
   parameter int SUM_W    = 18,
   parameter int PROD_W   = 36,
   parameter int RES_LSB  = 6,
   parameter int RES_MSB  = 23,
   parameter int CIW      = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_vld,
   input  logic [CIW-1:0]             in_ch,
   input  logic [DATA_W-1:0]          in_raw,
   input  logic signed [OFFSET_W-1:0] in_off,
   input  logic signed [FACTOR_W-1:0] in_fac,
   output logic                       out_vld,
   output logic [CIW-1:0]             out_ch,
   output logic [RES_MSB-RES_LSB:0]   out_win
);
   localparam int RAW_PAD = SUM_W - DATA_W;
   localparam int OFF_PAD = SUM_W - OFFSET_W;

   logic signed [SUM_W-1:0]    raw_ext, off_ext;
   logic signed [SUM_W-1:0]    s1_sum;
   logic signed [FACTOR_W-1:0] s1_fac;
   logic [CIW-1:0]             s1_ch;
   logic                       s1_vld;
   logic signed [PROD_W-1:0]   s2_prod;
   logic [CIW-1:0]             s2_ch;
   logic                       s2_vld;

   assign raw_ext = {{RAW_PAD{1'b0}}, in_raw};
   assign off_ext = {{OFF_PAD{in_off[OFFSET_W-1]}}, in_off};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_sum  <= '0;
         s1_fac  <= '0;
         s1_ch   <= '0;
         s2_vld  <= 1'b0;
         s2_prod <= '0;
         s2_ch   <= '0;
      end else begin
         s1_vld  <= in_vld;
         s1_sum  <= raw_ext + off_ext;
         s1_fac  <= in_fac;
         s1_ch   <= in_ch;
         s2_vld  <= s1_vld;
         s2_prod <= s1_sum * s1_fac;
         s2_ch   <= s1_ch;
      end
   end

   assign out_vld = s2_vld;
   assign out_ch  = s2_ch;
   assign out_win = s2_prod[RES_MSB:RES_LSB];

   // R5
   pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(in_vld, 2));

   // R5
   pipe_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (s1_ch == $past(in_ch)));

endmodule

// File: rtl/scl_scale_top.sv
module scl_scale_top #(
   parameter  int DATA_W   = 16,
   parameter  int CHANNELS = 8,
   parameter  int OFFSET_W = 16,
   parameter  int FACTOR_W = 18,
   parameter  int RES_LSB  = 6,
   parameter  int RES_MSB  = 23,
   localparam int CIW      = scl_pkg::idx_w(CHANNELS),
   localparam int CFG_W    = scl_pkg::max2(OFFSET_W, FACTOR_W),
   localparam int RES_W    = RES_MSB - RES_LSB + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         samp_valid,
   input  logic [CHANNELS*DATA_W-1:0]   samp_raw,
   input  logic                         cfg_we,
   input  logic                         cfg_sel,
   input  logic [CIW-1:0]               cfg_ch,
   input  logic [CFG_W-1:0]             cfg_data,
   output logic [CHANNELS*RES_W-1:0]    res_bus,
   output logic                         res_valid,
   output logic                         busy
);
   import scl_pkg::*;

   localparam int SUM_W  = max2(DATA_W + 1, OFFSET_W) + 1;
   localparam int PROD_W = SUM_W + FACTOR_W;
   localparam logic [CIW-1:0] LAST_CH = CIW'(CHANNELS - 1);

   initial begin
      assert (DATA_W >= 1 && DATA_W <= 24) else $error("DATA_W out of range");
      assert (CHANNELS >= 1 && CHANNELS <= 32) else $error("CHANNELS out of range");
      assert (FACTOR_W >= 1 && FACTOR_W <= 18) else $error("FACTOR_W out of range");
      assert (OFFSET_W >= 1) else $error("OFFSET_W out of range");
      assert (RES_LSB >= 0 && RES_LSB <= RES_MSB) else $error("result window inverted");
      assert (RES_MSB < PROD_W) else $error("result window beyond product");
   end

   logic                         accept, iss_vld, drain_done;
   logic [CIW-1:0]               iss_ch, out_ch;
   logic [CHANNELS*DATA_W-1:0]   raw_hold;
   logic signed [OFFSET_W-1:0]   cur_off;
   logic signed [FACTOR_W-1:0]   cur_fac;
   logic                         out_vld;
   logic [RES_W-1:0]             out_win;
   logic                         done_q;

   scl_issue_seq #(.CHANNELS(CHANNELS), .CIW(CIW)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(samp_valid), .drain_done(drain_done),
      .accept(accept), .busy(busy), .iss_vld(iss_vld), .iss_ch(iss_ch)
   );

   scl_coef_bank #(.CHANNELS(CHANNELS), .OFFSET_W(OFFSET_W), .FACTOR_W(FACTOR_W),
                   .CIW(CIW), .CFG_W(CFG_W)) coef_i (
      .clk(clk), .rst_n(rst_n), .lock(busy), .wr_en(cfg_we),
      .wr_sel(coef_sel_e'(cfg_sel)), .wr_ch(cfg_ch), .wr_data(cfg_data),
      .rd_ch(iss_ch), .rd_off(cur_off), .rd_fac(cur_fac)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      raw_hold <= '0;
      else if (accept) raw_hold <= samp_raw;
   end

   scl_mac_pipe #(.DATA_W(DATA_W), .OFFSET_W(OFFSET_W), .FACTOR_W(FACTOR_W),
                  .SUM_W(SUM_W), .PROD_W(PROD_W), .RES_LSB(RES_LSB),
                  .RES_MSB(RES_MSB), .CIW(CIW)) mac_i (
      .clk(clk), .rst_n(rst_n), .in_vld(iss_vld), .in_ch(iss_ch),
      .in_raw(raw_hold[iss_ch*DATA_W +: DATA_W]), .in_off(cur_off), .in_fac(cur_fac),
      .out_vld(out_vld), .out_ch(out_ch), .out_win(out_win)
   );

   assign drain_done = out_vld && (out_ch == LAST_CH);

   for (genvar c = 0; c < CHANNELS; c++) begin : g_slot
      logic [RES_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                               slot_q <= '0;
         else if (out_vld && out_ch == CIW'(c))    slot_q <= out_win;
      end
      assign res_bus[c*RES_W +: RES_W] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= drain_done;
   end
   assign res_valid = done_q;

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R4
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (!busy && $past(busy)));

   // R6
   raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(raw_hold));

endmodule

// File: tb/scl_scale_top_tb.sv
module scl_scale_top_tb_top;
   localparam int N    = 8;
   localparam int DW   = 16;
   localparam int OW   = 16;
   localparam int FW   = 18;
   localparam int LSB  = 6;
   localparam int MSB  = 23;
   localparam int RW   = MSB - LSB + 1;
   localparam int CIW  = 3;
   localparam int CFGW = 18;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              samp_valid = 1'b0;
   logic [N*DW-1:0]   samp_raw = '0;
   logic              cfg_we = 1'b0;
   logic              cfg_sel = 1'b0;
   logic [CIW-1:0]    cfg_ch = '0;
   logic [CFGW-1:0]   cfg_data = '0;
   logic [N*RW-1:0]   res_bus;
   logic              res_valid;
   logic              busy;

   always #2.5 clk = ~clk;

   scl_scale_top #(.DATA_W(DW), .CHANNELS(N), .OFFSET_W(OW), .FACTOR_W(FW),
                   .RES_LSB(LSB), .RES_MSB(MSB)) dut_i (
      .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_raw(samp_raw),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ch(cfg_ch), .cfg_data(cfg_data),
      .res_bus(res_bus), .res_valid(res_valid), .busy(busy)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string req = "R1";

   // reference model state
   bit              m_busy = 0;
   bit              m_rv = 0;
   int              m_t = 0;
   longint          m_raw [N];
   longint          m_off [N];
   longint          m_fac [N];
   logic [RW-1:0]   m_slot [N];

   function automatic logic [RW-1:0] ref_val(longint raw, longint off, longint fac);
      longint p;
      p = (raw + off) * fac;
      return RW'(p >>> LSB);
   endfunction

   initial begin
      for (int c = 0; c < N; c++) begin
         m_raw[c] = 0; m_off[c] = 0; m_fac[c] = 0; m_slot[c] = '0;
      end
   end

   always @(posedge clk) begin
      bit was_busy;
      was_busy = m_busy;
      if (!rst_n) begin
         m_busy = 0; m_rv = 0; m_t = 0;
         for (int c = 0; c < N; c++) begin
            m_off[c] = 0; m_fac[c] = 0; m_slot[c] = '0;
         end
      end else begin
         m_rv = 0;
         if (was_busy) begin
            m_t++;
            if (m_t >= 3 && m_t - 3 < N)
               m_slot[m_t-3] = ref_val(m_raw[m_t-3], m_off[m_t-3], m_fac[m_t-3]);
            if (m_t == N + 2) begin
               m_busy = 0;
               m_rv = 1;
            end
         end
         if (cfg_we && !was_busy && int'(cfg_ch) < N) begin
            if (cfg_sel) m_fac[cfg_ch] = longint'($signed(cfg_data[FW-1:0]));
            else         m_off[cfg_ch] = longint'($signed(cfg_data[OW-1:0]));
         end
         if (samp_valid && !was_busy) begin
            m_busy = 1;
            m_t = 0;
            for (int c = 0; c < N; c++) m_raw[c] = longint'(samp_raw[c*DW +: DW]);
         end
      end
   end

   task automatic check(string tag, string what, longint act, longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < N; c++)
            check(req, $sformatf("slot %0d (R2/R3 value, R5 timing)", c),
                  longint'(res_bus[c*RW +: RW]), longint'(m_slot[c]));
         check(req, "res_valid (R5)", longint'(res_valid), longint'(m_rv));
         check(req, "busy (R4)", longint'(busy), longint'(m_busy));
      end
   end

   task automatic wr(input bit sel, input int ch, input longint val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_ch = CIW'(ch); cfg_data = CFGW'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run(input logic [N*DW-1:0] raw, input int idle);
      @(negedge clk);
      samp_valid = 1'b1; samp_raw = raw;
      @(negedge clk);
      samp_valid = 1'b0;
      repeat (idle) @(negedge clk);
   endtask

   function automatic logic [N*DW-1:0] pat(int seed);
      logic [N*DW-1:0] v;
      for (int c = 0; c < N; c++) v[c*DW +: DW] = DW'(seed * (c + 3) * 2654435 + c * 977);
      return v;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs at reset
      check("R1", "res_bus in reset", longint'(res_bus != '0), 0);
      check("R1", "res_valid in reset", longint'(res_valid), 0);
      check("R1", "busy in reset", longint'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "res_bus after reset", longint'(res_bus != '0), 0);

      // R7: load per-channel coefficients, mixed signs
      req = "R7";
      for (int c = 0; c < N; c++) begin
         wr(1'b0, c, longint'(c * 1100 - 4000));
         wr(1'b1, c, longint'((c - 4) * 1700 + 75));
      end

      // R2 R3: main function, distinct patterns per channel
      req = "R2";
      run(pat(1), N + 3);
      req = "R3";
      run(pat(7), N + 3);

      // R9: extremes of raw, offset and factor
      req = "R9";
      wr(1'b0, 0, -32768);
      wr(1'b1, 0, -131072);
      wr(1'b0, N - 1, 32767);
      wr(1'b1, N - 1, 131071);
      wr(1'b0, 1, 0);
      wr(1'b1, 1, 1 << LSB);
      run({(N*DW){1'b1}}, N + 3);
      run('0, N + 3);

      // R6: new requests during a run are dropped
      req = "R6";
      @(negedge clk);
      samp_valid = 1'b1; samp_raw = pat(3);
      @(negedge clk);
      samp_raw = pat(4);
      repeat (4) @(negedge clk);
      samp_raw = pat(5);
      repeat (2) @(negedge clk);
      samp_valid = 1'b0;
      repeat (N + 3) @(negedge clk);

      // R8: writes during a run are dropped; a later run shows old coefficients
      req = "R8";
      @(negedge clk);
      samp_valid = 1'b1; samp_raw = pat(9);
      @(negedge clk);
      samp_valid = 1'b0;
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_ch = 3'd2; cfg_data = CFGW'(12345);
      @(negedge clk);
      cfg_sel = 1'b0; cfg_ch = 3'd5; cfg_data = CFGW'(-777);
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (N + 2) @(negedge clk);
      run(pat(11), N + 3);

      // R4 R5: request held high, sets run back to back
      req = "R5";
      @(negedge clk);
      samp_valid = 1'b1;
      for (int i = 0; i < 3 * (N + 3); i++) begin
         samp_raw = pat(20 + i);
         @(negedge clk);
      end
      samp_valid = 1'b0;
      req = "R4";
      repeat (N + 3) @(negedge clk);

      // R10: slots hold across idle cycles and accepted coefficient writes
      req = "R10";
      wr(1'b1, 4, 999);
      wr(1'b0, 4, -5);
      repeat (10) @(negedge clk);
      run(pat(42), N + 3);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule